// File: doc/BRIEF.md
# Claim/Complete Interrupt Controller

This block collects level-sensitive interrupt requests from peripheral devices and folds them into one external interrupt line for a single processor context. Each source has a small priority field and an enable bit, and one threshold register decides how urgent a request must be before it reaches the core. Identifier 0 is reserved and means "nothing to service", so the default build serves sources 1 to 63 out of 64 identifier slots.

Software handles an interrupt with a fixed three-step handshake. It reads the claim register to learn which source to serve. It clears the condition inside that device. It then writes the same identifier back to the same register. Between claim and completion the source is held in service and is not seen as pending. If the device request is still high when completion arrives, the line asserts again. The line keeps re-triggering this way until every enabled device has been quietened.

Register access uses a simple request channel with valid/ready. `bus_ready` is held high, so every request is accepted in the cycle it is presented and the channel never exerts back-pressure. A read returns its data on `rsp_valid`/`rsp_data` exactly one cycle after acceptance. Writes return no response. The core-side enables are folded in through a single qualifier input.

Top module: `irq_hub`

## Requirements
- R1: After reset every priority, enable bit and the threshold read as 0, no source is in service, `ext_irq` is 0 and a claim returns 0.
- R2: The priority of source n is a 3-bit field read and written at byte address 4*n (0x000 to 0x0FC); wider write data is truncated to 3 bits, and source 0 always reads 0.
- R3: The enable bit of source n is bit (n mod 32) of the word at byte address 0x200 + 4*(n/32); bit 0 of word 0 (source 0) is hardwired 0.
- R4: `ext_irq` is high exactly when `core_irq_en` is high and at least one source is pending, enabled and has a priority strictly above the threshold; a source with priority 0 never raises it.
- R5: A read of the claim/complete register (byte address 0x304) returns the eligible source with the highest priority, with ties going to the lowest identifier, and returns 0 when no source is eligible.
- R6: A claim that returns a non-zero identifier places that source in service; it is no longer pending, and `ext_irq` falls if no other source is eligible, even while its request stays high.
- R7: A write of an in-service identifier to 0x304 releases it; if its request is still high, it is pending again from the cycle after the write. If its request is low, it stays idle.
- R8: A write to 0x304 of an identifier that is not in service, or that is 64 or more, changes nothing.
- R9: The threshold is a 3-bit register at byte address 0x300; a source whose priority equals the threshold is not eligible.
- R10: `bus_ready` is always high. An accepted read raises `rsp_valid` for one cycle, one clock after acceptance. An accepted write never raises `rsp_valid`.
- R11: Pending follows the request level: a request that drops before it is claimed stops being pending one cycle later, and a later claim returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 64 | Level request per source identifier (bit 0 unused) |
| core_irq_en | input | 1 | Core-side qualifier for the external interrupt |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| ext_irq | output | 1 | External interrupt line to the core |

## Verification
On every cycle, the assertions check the response timing of the register channel and that a raised `ext_irq` always has its core qualifier. They also check that any non-zero winner really is pending, enabled and above the threshold. Around claims and completions, they check that a claim places its winner in service, that a valid completion releases it, and that an invalid completion leaves the in-service set unchanged. The bench scenarios are the only place where arbitration order can be seen, including the tie toward the lowest identifier. They also show the register address layout and field truncation, the re-triggering after completion while a request is still high, and the loss of a request that was dropped before it was claimed.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  // Byte offsets of the register regions.
  localparam int unsigned PRIO_BASE = 'h000;
  localparam int unsigned EN_BASE   = 'h200;
  localparam int unsigned THR_OFS   = 'h300;
  localparam int unsigned CLAIM_OFS = 'h304;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } reg_sel_e;

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter int NUM_SRC = 64,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               claim_fire,
  input  logic [ID_W-1:0]    claim_id,
  input  logic               complete_fire,
  input  logic               complete_ok,
  input  logic [ID_W-1:0]    complete_id,
  output logic [NUM_SRC-1:0] pending
);

  logic [NUM_SRC-1:0] svc_q;
  logic [NUM_SRC-1:0] svc_d;

  // One service/pending cell per identifier; identifier 0 is tied off.
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_cell
    if (n == 0) begin : g_rsvd
      assign svc_d[n] = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          svc_q[n]   <= 1'b0;
          pending[n] <= 1'b0;
        end else begin
          svc_q[n]   <= 1'b0;
          pending[n] <= 1'b0;
        end
      end
    end else begin : g_live
      logic take;
      logic give;
      assign take = claim_fire && (claim_id == ID_W'(n));
      assign give = complete_fire && complete_ok && (complete_id == ID_W'(n)) && svc_q[n];
      assign svc_d[n] = take ? 1'b1 : (give ? 1'b0 : svc_q[n]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          svc_q[n]   <= 1'b0;
          pending[n] <= 1'b0;
        end else begin
          svc_q[n]   <= svc_d[n];
          pending[n] <= src_req[n] && !svc_d[n];
        end
      end
    end
  end

  p_claim_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire && claim_id != '0) |=> (svc_q[$past(claim_id)] && !pending[$past(claim_id)]));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_fire && complete_ok && !claim_fire && svc_q[complete_id])
      |=> !svc_q[$past(complete_id)]);

  p_bad_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_fire && !claim_fire && (!complete_ok || !svc_q[complete_id]))
      |=> $stable(svc_q));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              pending,
  input  logic [NUM_SRC-1:0]              enable,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
  input  logic [PRIO_W-1:0]               threshold,
  output logic [ID_W-1:0]                 best_id
);

  logic [PRIO_W-1:0] best_p;

  // Linear scan from low to high id: strict compare keeps the lowest id on ties,
  // and seeding with the threshold makes "above threshold" part of the compare.
  always_comb begin
    best_id = '0;
    best_p  = threshold;
    for (int n = 1; n < NUM_SRC; n++) begin
      if (pending[n] && enable[n] && (prio[n] > best_p)) begin
        best_p  = prio[n];
        best_id = ID_W'(n);
      end
    end
  end

  p_winner_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (best_id != '0) |-> (pending[best_id] && enable[best_id]));

  p_winner_above_thr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (best_id != '0) |-> (prio[best_id] > threshold));

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_valid,
  input  logic                           bus_write,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [ID_W-1:0]                claim_id,
  output logic                           rsp_valid,
  output logic [DATA_W-1:0]              rsp_data,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic [NUM_SRC-1:0]             enable,
  output logic [PRIO_W-1:0]              threshold,
  output logic                           claim_fire,
  output logic                           complete_fire,
  output logic                           complete_ok,
  output logic [ID_W-1:0]                complete_id
);

  localparam int EN_WORDS = (NUM_SRC + 31) / 32;
  localparam int EN_BITS  = EN_WORDS * 32;
  localparam int EW_W     = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
  localparam logic [EN_BITS-1:0] EN_MASK = (EN_BITS'(1) << NUM_SRC) - EN_BITS'(2);

  reg_sel_e                        sel;
  logic [ADDR_W-3:0]               wsel;
  logic [ID_W-1:0]                 pidx;
  logic [EW_W-1:0]                 ew;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic [EN_BITS-1:0]              en_q;
  logic [PRIO_W-1:0]               thr_q;
  logic [DATA_W-1:0]               rd_next;
  logic                            rd_fire;
  logic                            wr_fire;

  assign wsel    = bus_addr[ADDR_W-1:2];
  assign pidx    = ID_W'(wsel);
  assign ew      = EW_W'(int'(wsel) - int'(EN_BASE / 4));
  assign rd_fire = bus_valid && !bus_write;
  assign wr_fire = bus_valid && bus_write;

  always_comb begin
    sel = RG_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      if (int'(bus_addr) < int'(PRIO_BASE) + 4 * NUM_SRC)
        sel = RG_PRIO;
      else if (int'(bus_addr) >= int'(EN_BASE) && int'(bus_addr) < int'(EN_BASE) + 4 * EN_WORDS)
        sel = RG_EN;
      else if (int'(bus_addr) == int'(THR_OFS))
        sel = RG_THR;
      else if (int'(bus_addr) == int'(CLAIM_OFS))
        sel = RG_CLAIM;
    end
  end

  assign claim_fire    = rd_fire && (sel == RG_CLAIM);
  assign complete_fire = wr_fire && (sel == RG_CLAIM);
  assign complete_ok   = (bus_wdata < DATA_W'(NUM_SRC));
  assign complete_id   = bus_wdata[ID_W-1:0];

  // Configuration storage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_fire) begin
      case (sel)
        RG_PRIO: if (pidx != '0) prio_q[pidx] <= bus_wdata[PRIO_W-1:0];
        RG_EN:   en_q[ew*32 +: 32] <= bus_wdata[31:0] & EN_MASK[ew*32 +: 32];
        RG_THR:  thr_q <= bus_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // Read data mux.
  always_comb begin
    rd_next = '0;
    case (sel)
      RG_PRIO:  rd_next = DATA_W'(prio_q[pidx]);
      RG_EN:    rd_next = DATA_W'(en_q[ew*32 +: 32]);
      RG_THR:   rd_next = DATA_W'(thr_q);
      RG_CLAIM: rd_next = DATA_W'(claim_id);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_data <= rd_next;
    end
  end

  assign prio      = prio_q;
  assign enable    = en_q[NUM_SRC-1:0];
  assign threshold = thr_q;

  p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);

  p_no_rsp_otherwise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rsp_valid);

  p_src0_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] && (prio_q[0] == '0));

endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               core_irq_en,
  input  logic               bus_valid,
  output logic               bus_ready,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               ext_irq
);

  localparam int ID_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [NUM_SRC-1:0]             enable;
  logic [PRIO_W-1:0]              threshold;
  logic [NUM_SRC-1:0]             pending;
  logic [ID_W-1:0]                best_id;
  logic                           claim_fire;
  logic                           complete_fire;
  logic                           complete_ok;
  logic [ID_W-1:0]                complete_id;

  assign bus_ready = 1'b1;

  irq_regs #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .claim_id(best_id),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .prio(prio), .enable(enable), .threshold(threshold),
    .claim_fire(claim_fire), .complete_fire(complete_fire),
    .complete_ok(complete_ok), .complete_id(complete_id)
  );

  irq_gateway #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .claim_fire(claim_fire), .claim_id(best_id),
    .complete_fire(complete_fire), .complete_ok(complete_ok), .complete_id(complete_id),
    .pending(pending)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .pending(pending), .enable(enable), .prio(prio), .threshold(threshold),
    .best_id(best_id)
  );

  assign ext_irq = core_irq_en && (best_id != '0);

  p_irq_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |-> core_irq_en);

  p_ready_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready);

endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NSRC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_req = '0;
  logic        core_irq_en = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        ext_irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_hub #(.NUM_SRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .core_irq_en(core_irq_en),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ext_irq(ext_irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    src_req = '0;
    core_irq_en = 1'b1;
    bus_valid = 1'b0;
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_valid = 1'b0; bus_write = 1'b0;
    chk("R10 no response after write", rsp_valid, 0);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    tick();
    bus_valid = 1'b0;
    chk("R10 response after read", rsp_valid, 1);
    d = rsp_data;
    tick();
    chk("R10 response lasts one cycle", rsp_valid, 0);
  endtask

  task automatic claim(output logic [31:0] id);
    rd(12'h304, id);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 irq low after reset", ext_irq, 0);
    chk("R10 ready high", bus_ready, 1);
    rd(12'h014, v); chk("R1 priority zero", v, 0);
    rd(12'h200, v); chk("R1 enable zero", v, 0);
    rd(12'h300, v); chk("R1 threshold zero", v, 0);
    claim(v);       chk("R1 claim empty", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    do_reset();
    wr(12'h014, 3);  rd(12'h014, v); chk("R2 priority src5", v, 3);
    wr(12'h000, 7);  rd(12'h000, v); chk("R2 priority src0 hardwired", v, 0);
    wr(12'h0A0, 32'hF); rd(12'h0A0, v); chk("R2 priority truncated", v, 7);
    wr(12'h204, 32'h100); rd(12'h204, v); chk("R3 enable src40 word1 bit8", v, 32'h100);
    wr(12'h200, 32'hFFFF_FFFF); rd(12'h200, v); chk("R3 enable bit0 hardwired", v, 32'hFFFF_FFFE);
    wr(12'h300, 32'h1D); rd(12'h300, v); chk("R9 threshold 3 bits", v, 5);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    do_reset();
    wr(12'h014, 3);
    wr(12'h200, 32'h60);         // sources 5 and 6
    wr(12'h300, 3);
    src_req[5] = 1'b1; src_req[6] = 1'b1;
    tick();
    chk("R9 priority equal threshold", ext_irq, 0);
    wr(12'h300, 2);
    chk("R4 eligible raises irq", ext_irq, 1);
    core_irq_en = 1'b0; #1;
    chk("R4 core qualifier", ext_irq, 0);
    core_irq_en = 1'b1;
    wr(12'h200, 32'h40);         // only source 6, priority 0
    wr(12'h300, 0);
    chk("R4 priority zero never interrupts", ext_irq, 0);
    claim(v); chk("R4 priority zero not claimed", v, 0);
  endtask

  task automatic t_select();
    logic [31:0] v;
    do_reset();
    wr(12'h028, 4);              // src 10
    wr(12'h030, 6);              // src 12
    wr(12'h050, 6);              // src 20
    wr(12'h200, (32'h1 << 10) | (32'h1 << 12) | (32'h1 << 20));
    src_req[10] = 1'b1; src_req[12] = 1'b1; src_req[20] = 1'b1;
    tick();
    chk("R4 irq with three eligible", ext_irq, 1);
    claim(v); chk("R5 highest priority lowest id", v, 12);
    claim(v); chk("R6 claimed not re-offered", v, 20);
    claim(v); chk("R5 next priority", v, 10);
    claim(v); chk("R6 all in service", v, 0);
    chk("R6 irq drops while requests high", ext_irq, 0);
  endtask

  task automatic t_complete();
    logic [31:0] v;
    t_select();
    wr(12'h304, 33);
    chk("R8 complete not in service", ext_irq, 0);
    wr(12'h304, 70);
    chk("R8 complete out of range", ext_irq, 0);
    claim(v); chk("R8 nothing released", v, 0);
    wr(12'h304, 20);
    chk("R7 active request re-triggers", ext_irq, 1);
    claim(v); chk("R7 reclaim same source", v, 20);
    src_req[20] = 1'b0;
    wr(12'h304, 20);
    chk("R7 cleared device stays quiet", ext_irq, 0);
    wr(12'h304, 12);
    chk("R7 second release re-triggers", ext_irq, 1);
    claim(v); chk("R7 reclaim after release", v, 12);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_reset();
    wr(12'h078, 5);              // src 30
    wr(12'h200, 32'h4000_0000);
    src_req[30] = 1'b1;
    tick();
    chk("R11 request pending", ext_irq, 1);
    src_req[30] = 1'b0;
    tick();
    chk("R11 dropped request not pending", ext_irq, 0);
    claim(v); chk("R11 claim after drop", v, 0);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_gate();
    t_select();
    t_complete();
    t_level();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule